// File: doc/BRIEF.md
# Cartridge ROM address translator

This block sits between a 24-bit console address bus and an 8 MB flash array. It takes the console address, an active-low cartridge strobe, read and write qualifiers, and a set of mapping configuration fields, and produces a 23-bit flash address with chip, output and write enables. It also produces a battery-RAM window select and a register-write decode select, which are passed to neighbouring logic.

Three operating states are covered. A boot state mirrors one 32 KB loader page into the whole cartridge space. A configured play state offers four banked layouts: 32 KB-bank, linear 64 KB-bank, and extended versions of each. It can also flip the top two flash address bits, so several titles can share the array at 2 MB offsets, and it can leave a coprocessor window unmapped. A program state maps the lower half of the console space flat onto flash and lets writes through. All outputs are registered once, so a result appears on the clock edge after the inputs are sampled.

Top module: `cart_rom_xlat`

## Requirements
- R1: While `cart_n_i` is high, none of `flash_ce_o`, `sram_sel_o` and `reg_sel_o` is asserted on the following cycle.
- R2: In configured play state with `hirom_i`=0 and `ext_i`=0, the flash address is `{1'b0, addr[22:16], addr[14:0]}`. For example, 018000 maps to 008000 and C00000 maps to 200000.
- R3: In configured play state with `hirom_i`=1 and `ext_i`=0, the flash address is `{1'b0, addr[21:0]}`.
- R4: In configured play state, banks 7E and 7F never select flash. When address bit 22 is 0 (banks 00-3F and 80-BF), flash is selected only when address bit 15 is 1.
- R5: With `ext_i`=1, flash address bit 22 is set whenever the console address is below C00000. Otherwise it stays 0.
- R6: `inv_i[0]` inverts flash address bit 21 and `inv_i[1]` inverts flash address bit 22. Both inversions are applied after the extended offset, in configured play state only.
- R7: With `cop_hole_i`=1, console addresses 300000-3FFFFF select nothing in configured play state. B00000-BFFFFF is unaffected.
- R8: With `prog_mode_i`=1, addresses 000000-7FFFFF map to flash address `addr[22:0]`, FE0000-FFFFFF select battery RAM, and 800000-FDFFFF select nothing.
- R9: With `prog_mode_i`=0 and `cfg_done_i`=0, every cartridge read selects flash at `{8'hFF, addr[14:0]}` (page 7F8000-7FFFFF).
- R10: In play state, battery RAM (700000-77FFFF while `bram_en_i`=1) and register writes (write with address bits 23:21 = 111 and bit 15 = 1) take priority over flash, so flash is never selected together with either.
- R11: `flash_oe_o` is asserted only for reads. `flash_we_o` is asserted only for writes in program state. A play-state write selects no flash.
- R12: All outputs are registered with one cycle of latency, and they are cleared while `rst_ni` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cart_n_i | input | 1 | Active-low cartridge strobe |
| rd_i | input | 1 | Read cycle |
| wr_i | input | 1 | Write cycle |
| addr_i | input | 24 | Console address |
| prog_mode_i | input | 1 | Program state, flat mapping |
| cfg_done_i | input | 1 | Mapping configured (0 = boot mirror) |
| hirom_i | input | 1 | Linear 64 KB-bank layout |
| ext_i | input | 1 | Extended layout offset |
| inv_i | input | 2 | Invert flash bits 21 and 22 |
| cop_hole_i | input | 1 | Leave 300000-3FFFFF unmapped |
| bram_en_i | input | 1 | Battery RAM window enable |
| flash_addr_o | output | 23 | Flash address |
| flash_ce_o | output | 1 | Flash chip enable |
| flash_oe_o | output | 1 | Flash output enable |
| flash_we_o | output | 1 | Flash write enable |
| sram_sel_o | output | 1 | Battery RAM window select |
| reg_sel_o | output | 1 | Register write decode |

## Verification
The assertions assume that `rd_i` and `wr_i` are never high together. They also assume that the address, the strobes and the configuration fields are settled at each rising edge, and that configuration changes only between accesses. The bench respects these assumptions: it changes every input at the falling edge, holds them through the following rising edge, drives at most one of the read and write qualifiers, and changes configuration fields only between accesses.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int INV_W = 2;

  typedef struct packed {
    logic             prog;
    logic             cfg_done;
    logic             hirom;
    logic             ext;
    logic [INV_W-1:0] inv;
    logic             cop_hole;
    logic             bram_en;
  } xlat_cfg_t;

  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_PLAY = 2'd1,
    ST_PROG = 2'd2
  } xlat_state_e;

  function automatic xlat_state_e state_of(xlat_cfg_t c);
    if (c.prog) return ST_PROG;
    if (!c.cfg_done) return ST_BOOT;
    return ST_PLAY;
  endfunction
endpackage

// File: rtl/xlat_region_dec.sv
module xlat_region_dec
  import xlat_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cart_n_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  xlat_cfg_t         cfg_i,
  output logic              fl_hit_o,
  output logic              sram_hit_o,
  output logic              reg_hit_o
);
  localparam int TOP = ADDR_W - 1;
  localparam int HALF_BIT = 15;

  xlat_state_e st;
  logic in_region;
  logic low_half_bank, wram_bank, cop_win;

  assign st = state_of(cfg_i);

  // 00-3F / 80-BF lower halves
  assign low_half_bank = !addr_i[TOP-1] && !addr_i[HALF_BIT];
  assign wram_bank     = (addr_i[TOP:TOP-6] == 7'b0111111);
  assign cop_win       = cfg_i.cop_hole && (addr_i[TOP:TOP-3] == 4'h3);

  always_comb begin
    sram_hit_o = 1'b0;
    reg_hit_o  = 1'b0;
    in_region  = 1'b0;
    if (!cart_n_i) begin
      unique case (st)
        ST_PROG: begin
          sram_hit_o = (addr_i[TOP:TOP-6] == 7'h7F);
          in_region  = !addr_i[TOP];
        end
        ST_BOOT: begin
          sram_hit_o = cfg_i.bram_en && (addr_i[TOP:TOP-4] == 5'b01110);
          reg_hit_o  = wr_i && (addr_i[TOP:TOP-2] == 3'b111) && addr_i[HALF_BIT];
          in_region  = 1'b1;
        end
        default: begin
          sram_hit_o = cfg_i.bram_en && (addr_i[TOP:TOP-4] == 5'b01110);
          reg_hit_o  = wr_i && (addr_i[TOP:TOP-2] == 3'b111) && addr_i[HALF_BIT];
          in_region  = !low_half_bank && !wram_bank && !cop_win;
        end
      endcase
    end
  end

  assign fl_hit_o = in_region && !sram_hit_o && !reg_hit_o &&
                    (rd_i || (wr_i && st == ST_PROG));
endmodule

// File: rtl/xlat_map.sv
module xlat_map
  import xlat_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int FLASH_W = 23
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  xlat_cfg_t          cfg_i,
  output logic [FLASH_W-1:0] faddr_o
);
  localparam int PAGE_W   = 15;
  localparam int BANK_LSB = PAGE_W + 1;
  localparam int LOW_W    = FLASH_W - INV_W;

  logic [FLASH_W-1:0] lo_a, hi_a, base_a, play_a, boot_a, prog_a;
  logic below_ext;

  assign lo_a   = {1'b0, addr_i[ADDR_W-2:BANK_LSB], addr_i[PAGE_W-1:0]};
  assign hi_a   = {1'b0, addr_i[FLASH_W-2:0]};
  assign boot_a = {{(FLASH_W-PAGE_W){1'b1}}, addr_i[PAGE_W-1:0]};
  assign prog_a = addr_i[FLASH_W-1:0];
  assign below_ext = !(addr_i[ADDR_W-1] && addr_i[ADDR_W-2]);

  always_comb begin
    base_a = cfg_i.hirom ? hi_a : lo_a;
    if (cfg_i.ext && below_ext) base_a[FLASH_W-1] = 1'b1;
  end

  assign play_a[LOW_W-1:0] = base_a[LOW_W-1:0];
  for (genvar i = 0; i < INV_W; i++) begin : g_inv
    assign play_a[LOW_W+i] = base_a[LOW_W+i] ^ cfg_i.inv[i];
  end

  always_comb begin
    unique case (state_of(cfg_i))
      ST_PROG: faddr_o = prog_a;
      ST_BOOT: faddr_o = boot_a;
      default: faddr_o = play_a;
    endcase
  end
endmodule

// File: rtl/xlat_out_reg.sv
module xlat_out_reg #(
  parameter int FLASH_W = 23
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [FLASH_W-1:0] faddr_i,
  input  logic               ce_i,
  input  logic               oe_i,
  input  logic               we_i,
  input  logic               sram_i,
  input  logic               reg_i,
  output logic [FLASH_W-1:0] faddr_o,
  output logic               ce_o,
  output logic               oe_o,
  output logic               we_o,
  output logic               sram_o,
  output logic               reg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      faddr_o <= '0;
      ce_o    <= 1'b0;
      oe_o    <= 1'b0;
      we_o    <= 1'b0;
      sram_o  <= 1'b0;
      reg_o   <= 1'b0;
    end else begin
      faddr_o <= faddr_i;
      ce_o    <= ce_i;
      oe_o    <= oe_i;
      we_o    <= we_i;
      sram_o  <= sram_i;
      reg_o   <= reg_i;
    end
  end
endmodule

// File: rtl/cart_rom_xlat.sv
module cart_rom_xlat
  import xlat_pkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int FLASH_W = 23
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cart_n_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               prog_mode_i,
  input  logic               cfg_done_i,
  input  logic               hirom_i,
  input  logic               ext_i,
  input  logic [INV_W-1:0]   inv_i,
  input  logic               cop_hole_i,
  input  logic               bram_en_i,
  output logic [FLASH_W-1:0] flash_addr_o,
  output logic               flash_ce_o,
  output logic               flash_oe_o,
  output logic               flash_we_o,
  output logic               sram_sel_o,
  output logic               reg_sel_o
);
  localparam int PAGE_W = 15;

  xlat_cfg_t cfg;
  logic fl_hit, sram_hit, reg_hit;
  logic [FLASH_W-1:0] map_addr;
  logic oe_d, we_d;

  assign cfg = '{prog: prog_mode_i, cfg_done: cfg_done_i, hirom: hirom_i,
                 ext: ext_i, inv: inv_i, cop_hole: cop_hole_i, bram_en: bram_en_i};

  xlat_region_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(addr_i), .cart_n_i(cart_n_i), .rd_i(rd_i), .wr_i(wr_i), .cfg_i(cfg),
    .fl_hit_o(fl_hit), .sram_hit_o(sram_hit), .reg_hit_o(reg_hit)
  );

  xlat_map #(.ADDR_W(ADDR_W), .FLASH_W(FLASH_W)) u_map (
    .addr_i(addr_i), .cfg_i(cfg), .faddr_o(map_addr)
  );

  assign oe_d = fl_hit && rd_i;
  assign we_d = fl_hit && wr_i && prog_mode_i;

  xlat_out_reg #(.FLASH_W(FLASH_W)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .faddr_i(map_addr), .ce_i(fl_hit), .oe_i(oe_d), .we_i(we_d),
    .sram_i(sram_hit), .reg_i(reg_hit),
    .faddr_o(flash_addr_o), .ce_o(flash_ce_o), .oe_o(flash_oe_o),
    .we_o(flash_we_o), .sram_o(sram_sel_o), .reg_o(reg_sel_o)
  );

  // R1
  desel_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cart_n_i |-> (!fl_hit && !sram_hit && !reg_hit));

  // R10
  sel_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fl_hit && (sram_hit || reg_hit)));

  // R4
  half_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_hit && !prog_mode_i && cfg_done_i && !addr_i[ADDR_W-2]) |-> addr_i[PAGE_W]);

  // R9
  boot_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_hit && !prog_mode_i && !cfg_done_i) |->
      (map_addr == {{(FLASH_W-PAGE_W){1'b1}}, addr_i[PAGE_W-1:0]}));

  // R8
  prog_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_hit && prog_mode_i) |-> (!addr_i[ADDR_W-1] && map_addr == addr_i[FLASH_W-1:0]));

  // R11
  we_prog_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flash_we_o |-> (flash_ce_o && !flash_oe_o));
endmodule

// File: tb/sim_cart_rom_xlat.sv
`timescale 1ns/1ps
module sim_cart_rom_xlat;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cart_n = 1'b1, rd = 1'b0, wr = 1'b0;
  logic [23:0] addr = '0;
  logic prog = 1'b0, cfgd = 1'b0, hirom = 1'b0, ext = 1'b0, cop = 1'b0, bram = 1'b0;
  logic [1:0] inv = 2'b00;
  logic [22:0] f_addr;
  logic f_ce, f_oe, f_we, s_sel, r_sel;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cart_rom_xlat u0 (
    .clk_i(clk), .rst_ni(rst_n), .cart_n_i(cart_n), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .prog_mode_i(prog), .cfg_done_i(cfgd), .hirom_i(hirom),
    .ext_i(ext), .inv_i(inv), .cop_hole_i(cop), .bram_en_i(bram),
    .flash_addr_o(f_addr), .flash_ce_o(f_ce), .flash_oe_o(f_oe),
    .flash_we_o(f_we), .sram_sel_o(s_sel), .reg_sel_o(r_sel)
  );

  task automatic acc(input logic [23:0] a, input logic r, input logic w, input logic cn = 1'b0);
    @(negedge clk);
    addr = a; rd = r; wr = w; cart_n = cn;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic e_ce, input logic [22:0] e_a,
                     input logic e_oe, input logic e_we, input logic e_s, input logic e_r);
    checks++;
    if (f_ce !== e_ce || f_oe !== e_oe || f_we !== e_we || s_sel !== e_s || r_sel !== e_r ||
        (e_ce && f_addr !== e_a)) begin
      errors++;
      $display("FAIL %s addr=%h: got ce%b oe%b we%b sram%b reg%b fa=%h exp ce%b oe%b we%b sram%b reg%b fa=%h",
               req, addr, f_ce, f_oe, f_we, s_sel, r_sel, f_addr,
               e_ce, e_oe, e_we, e_s, e_r, e_a);
    end
  endtask

  task automatic rd_flash(input string req, input logic [23:0] a, input logic [22:0] e);
    acc(a, 1'b1, 1'b0);
    chk(req, 1'b1, e, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic rd_none(input string req, input logic [23:0] a);
    acc(a, 1'b1, 1'b0);
    chk(req, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic set_play(input logic h, input logic e, input logic [1:0] iv);
    @(negedge clk);
    prog = 1'b0; cfgd = 1'b1; hirom = h; ext = e; inv = iv; cop = 1'b0; bram = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R12", 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_deselect;
    acc(24'h008000, 1'b1, 1'b0, 1'b1);
    chk("R1", 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    acc(24'hE08000, 1'b0, 1'b1, 1'b1);
    chk("R1", 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_boot;
    @(negedge clk); prog = 1'b0; cfgd = 1'b0;
    rd_flash("R9", 24'h123456, 23'h7FB456);
    rd_flash("R9", 24'hC0F123, 23'h7FF123);
    rd_flash("R9", 24'h000000, 23'h7F8000);
  endtask

  task automatic t_lorom;
    set_play(1'b0, 1'b0, 2'b00);
    rd_flash("R2", 24'h008000, 23'h000000);
    rd_flash("R2", 24'h018000, 23'h008000);
    rd_flash("R2", 24'hC00000, 23'h200000);
    rd_flash("R2", 24'h7D8000, 23'h3E8000);
  endtask

  task automatic t_hirom;
    set_play(1'b1, 1'b0, 2'b00);
    rd_flash("R3", 24'h408000, 23'h008000);
    rd_flash("R3", 24'hC10000, 23'h010000);
    rd_flash("R3", 24'h3F8000, 23'h3F8000);
  endtask

  task automatic t_ext;
    set_play(1'b0, 1'b1, 2'b00);
    rd_flash("R5", 24'h808000, 23'h400000);
    rd_flash("R5", 24'hC00000, 23'h200000);
    set_play(1'b1, 1'b1, 2'b00);
    rd_flash("R5", 24'h400000, 23'h400000);
    rd_flash("R5", 24'hC08000, 23'h008000);
  endtask

  task automatic t_inv;
    set_play(1'b0, 1'b0, 2'b01);
    rd_flash("R6", 24'h018000, 23'h208000);
    set_play(1'b0, 1'b0, 2'b10);
    rd_flash("R6", 24'h018000, 23'h408000);
    set_play(1'b0, 1'b0, 2'b11);
    rd_flash("R6", 24'h018000, 23'h608000);
    set_play(1'b1, 1'b1, 2'b10);
    rd_flash("R6", 24'h400000, 23'h000000);
  endtask

  task automatic t_holes;
    set_play(1'b0, 1'b0, 2'b00);
    rd_none("R4", 24'h000000);
    rd_none("R4", 24'h807FFF);
    rd_none("R4", 24'h7E8000);
    rd_none("R4", 24'h7F0000);
    rd_flash("R4", 24'h400000, 23'h200000);
  endtask

  task automatic t_cop;
    set_play(1'b0, 1'b0, 2'b00);
    rd_flash("R7", 24'h308000, 23'h180000);
    @(negedge clk); cop = 1'b1;
    rd_none("R7", 24'h308000);
    rd_none("R7", 24'h3F8000);
    rd_flash("R7", 24'hB08000, 23'h180000);
  endtask

  task automatic t_prog;
    @(negedge clk); prog = 1'b1; cfgd = 1'b0; inv = 2'b11; ext = 1'b1;
    rd_flash("R8", 24'h123456, 23'h123456);
    acc(24'h7FFFFF, 1'b0, 1'b1);
    chk("R8 R11", 1'b1, 23'h7FFFFF, 1'b0, 1'b1, 1'b0, 1'b0);
    rd_none("R8", 24'h800000);
    rd_none("R8", 24'hFDFFFF);
    acc(24'hFE1234, 1'b1, 1'b0);
    chk("R8", 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    acc(24'hE08000, 1'b0, 1'b1);
    chk("R8", 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sram_reg;
    set_play(1'b0, 1'b0, 2'b00);
    @(negedge clk); bram = 1'b1;
    acc(24'h708000, 1'b1, 1'b0);
    chk("R10", 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    acc(24'h77FFFF, 1'b0, 1'b1);
    chk("R10", 1'b0, '0, 1'b0, 1'b0, 1'b1, 1'b0);
    rd_flash("R10", 24'h780000, 23'h3C0000);
    @(negedge clk); bram = 1'b0;
    rd_flash("R10", 24'h700000, 23'h380000);
    acc(24'hE08000, 1'b0, 1'b1);
    chk("R10", 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    acc(24'hF8FFFF, 1'b0, 1'b1);
    chk("R10", 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
    rd_flash("R10", 24'hE08000, 23'h300000);
    @(negedge clk); cfgd = 1'b0;
    acc(24'hE08000, 1'b0, 1'b1);
    chk("R10", 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_play_write;
    set_play(1'b0, 1'b0, 2'b00);
    acc(24'h008000, 1'b0, 1'b1);
    chk("R11", 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    acc(24'h408000, 1'b0, 1'b0);
    chk("R11", 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_latency;
    set_play(1'b1, 1'b0, 2'b00);
    @(negedge clk); addr = 24'hC12345; rd = 1'b1; cart_n = 1'b0;
    #2;
    checks++;
    if (f_ce !== 1'b0) begin
      errors++;
      $display("FAIL R12 output before edge: ce=%b exp 0", f_ce);
    end
    @(posedge clk); #1;
    chk("R12", 1'b1, 23'h012345, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R12", 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_deselect();
    t_boot();
    t_lorom();
    t_hirom();
    t_ext();
    t_inv();
    t_holes();
    t_cop();
    t_prog();
    t_sram_reg();
    t_play_write();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout exp finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule